// File: doc/BRIEF.md
# Next Program Counter Unit

This block holds the program counter of a 32-bit word-aligned processor and picks the address of the following instruction each cycle. The decode stage presents a class code for the current instruction together with its 16-bit branch displacement, its 26-bit jump field and a register operand. The execute stage presents a flag that says whether the two compared registers are equal. From these the unit selects among fall-through, a PC-relative branch, a region-preserving direct jump, or a register-indirect jump. For calls it also offers a return address for the return-address register.

A small two-state controller tracks alignment faults. In state `ST_RUN` the PC advances normally. A register-indirect jump whose target has nonzero low two bits takes the transition `RUN_TO_FAULT`. In that case the PC is left unchanged and the controller enters `ST_FAULT`, which drives the `misaligned` output. Another bad target keeps the controller in `ST_FAULT` (`FAULT_HOLD`). Any accepted good instruction takes `FAULT_TO_RUN`. A good instruction in `ST_RUN` takes `RUN_HOLD`. While `hold` is high, neither the state nor the PC changes. A synchronous reset forces `ST_RUN` and loads the reset vector.

Top module: `pc_next_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the next value is `pc` = `RESET_VEC` (default 0x0040_0000) and `misaligned` = 0.
- R2: Class code 0 (sequential), and the unused codes 6 and 7, set `pc` to `pc` + 4 at the next edge.
- R3: Class code 1 (branch if equal) with `ops_equal` = 1 sets `pc` to `pc` + 4 + (sign-extended `br_disp` × 4). An encoding of 25 lands 100 bytes beyond `pc` + 4. With `ops_equal` = 0 it falls through to `pc` + 4.
- R4: Class code 2 (branch if not equal) is taken with `ops_equal` = 0 and falls through with `ops_equal` = 1. The target is computed as in R3.
- R5: A displacement with bit 15 set is negative, so the branch moves backwards. For example, 0xFFFD moves the target 12 bytes before `pc` + 4.
- R6: Class code 3 (jump) sets `pc` to {bits 31:28 of (`pc` + 4), `jmp_field`, 2'b00}. The region bits therefore come from the next instruction's address, even across a 256 MB boundary.
- R7: Class code 4 (jump and link) jumps as in R6. While that code is presented, `link_we` = 1 and `link_addr` = `pc` + 4. For every other code, `link_we` = 0.
- R8: Class code 5 (jump register) with `reg_target`[1:0] = 0 sets `pc` to `reg_target`.
- R9: Class code 5 with `reg_target`[1:0] ≠ 0 leaves `pc` unchanged and sets `misaligned` = 1 after the edge. The flag stays set across further bad targets and clears after the next accepted instruction of any other kind.
- R10: With `hold` = 1 (and `rst` = 0), `pc` and `misaligned` keep their values whatever class is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst | input | 1 | Synchronous reset, active high |
| hold | input | 1 | Freezes PC and fault state |
| instr_class | input | 3 | Class code of the current instruction (0..5) |
| br_disp | input | 16 | Branch displacement in words, two's complement |
| jmp_field | input | 26 | Word-address field of a direct jump |
| reg_target | input | 32 | Register operand for register-indirect jump |
| ops_equal | input | 1 | Compared registers are equal |
| pc | output | 32 | Current program counter |
| link_addr | output | 32 | Return address (`pc` + 4) |
| link_we | output | 1 | Write strobe for the return-address register |
| misaligned | output | 1 | Last register-indirect target was unaligned |

## Verification
On every cycle, the checker confirms the following: reset loads the vector; a hold freezes both the PC and the flag; fall-through adds four; direct jumps keep the region bits of `pc` + 4; a bad register target freezes the PC and raises the flag; the link strobe only accompanies the call class; and the PC stays word-aligned. The remaining behaviours depend on scenarios and are shown only by the bench's directed tests: branch polarity against the equality flag, backward displacement, a jump straddling a 256 MB boundary, a good register-indirect target, and the flag staying set across repeated faults before clearing.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

    typedef enum logic [2:0] {
        IC_SEQ = 3'd0,
        IC_BEQ = 3'd1,
        IC_BNE = 3'd2,
        IC_JMP = 3'd3,
        IC_JAL = 3'd4,
        IC_JR  = 3'd5
    } instr_class_e;

    typedef enum logic {
        ST_RUN   = 1'b0,
        ST_FAULT = 1'b1
    } pcu_state_e;

endpackage

// File: rtl/pcu_targets.sv
module pcu_targets #(
    parameter int ADDR_W   = 32,
    parameter int DISP_W   = 16,
    parameter int FIELD_W  = 26,
    parameter int REGION_W = 4
) (
    input  logic [ADDR_W-1:0]  cur_pc,
    input  logic [DISP_W-1:0]  disp,
    input  logic [FIELD_W-1:0] field,
    output logic [ADDR_W-1:0]  seq_addr,
    output logic [ADDR_W-1:0]  br_addr,
    output logic [ADDR_W-1:0]  jmp_addr
);
    localparam int EXT_W = ADDR_W - DISP_W - 2;
    localparam int PAD_W = ADDR_W - REGION_W - FIELD_W;

    logic [ADDR_W-1:0] disp_bytes;

    always_comb begin
        seq_addr   = cur_pc + ADDR_W'(4);
        disp_bytes = {{EXT_W{disp[DISP_W-1]}}, disp, 2'b00};
        br_addr    = seq_addr + disp_bytes;
        jmp_addr   = {seq_addr[ADDR_W-1 -: REGION_W], field, {PAD_W{1'b0}}};
    end
endmodule

// File: rtl/pcu_select.sv
module pcu_select
    import pcu_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [2:0]        cls,
    input  logic              eq,
    input  logic [ADDR_W-1:0] seq_addr,
    input  logic [ADDR_W-1:0] br_addr,
    input  logic [ADDR_W-1:0] jmp_addr,
    input  logic [ADDR_W-1:0] reg_addr,
    output logic [ADDR_W-1:0] next_addr,
    output logic              bad_target,
    output logic              call
);
    always_comb begin
        next_addr  = seq_addr;
        bad_target = 1'b0;
        call       = 1'b0;
        case (cls)
            IC_BEQ:  next_addr = eq ? br_addr : seq_addr;
            IC_BNE:  next_addr = eq ? seq_addr : br_addr;
            IC_JMP:  next_addr = jmp_addr;
            IC_JAL: begin
                next_addr = jmp_addr;
                call      = 1'b1;
            end
            IC_JR: begin
                next_addr  = reg_addr;
                bad_target = (reg_addr[1:0] != 2'b00);
            end
            default: next_addr = seq_addr;
        endcase
    end
endmodule

// File: rtl/pcu_ctrl.sv
module pcu_ctrl
    import pcu_pkg::*;
#(
    parameter int               ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] RESET_VEC = 32'h0040_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hold,
    input  logic              bad_target,
    input  logic [ADDR_W-1:0] next_addr,
    output logic [ADDR_W-1:0] pc_q,
    output logic              fault
);
    pcu_state_e state_q, state_d;
    logic       load_pc;

    // Next-state: RUN_HOLD, RUN_TO_FAULT, FAULT_HOLD, FAULT_TO_RUN
    always_comb begin
        state_d = state_q;
        load_pc = 1'b0;
        if (!hold) begin
            unique case (state_q)
                ST_RUN: begin
                    state_d = bad_target ? ST_FAULT : ST_RUN;
                    load_pc = !bad_target;
                end
                ST_FAULT: begin
                    state_d = bad_target ? ST_FAULT : ST_RUN;
                    load_pc = !bad_target;
                end
                default: state_d = ST_RUN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RUN;
            pc_q    <= RESET_VEC;
        end else begin
            state_q <= state_d;
            if (load_pc) pc_q <= next_addr;
        end
    end

    always_comb begin
        fault = (state_q == ST_FAULT);
    end
endmodule

// File: rtl/pc_next_unit.sv
module pc_next_unit #(
    parameter int               ADDR_W    = 32,
    parameter int               DISP_W    = 16,
    parameter int               FIELD_W   = 26,
    parameter int               REGION_W  = 4,
    parameter logic [ADDR_W-1:0] RESET_VEC = 32'h0040_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hold,
    input  logic [2:0]        instr_class,
    input  logic [DISP_W-1:0] br_disp,
    input  logic [FIELD_W-1:0] jmp_field,
    input  logic [ADDR_W-1:0] reg_target,
    input  logic              ops_equal,
    output logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] link_addr,
    output logic              link_we,
    output logic              misaligned
);
    logic [ADDR_W-1:0] seq_addr, br_addr, jmp_addr, next_addr;
    logic              bad_target;

    pcu_targets #(
        .ADDR_W(ADDR_W), .DISP_W(DISP_W), .FIELD_W(FIELD_W), .REGION_W(REGION_W)
    ) u_targets (
        .cur_pc   (pc),
        .disp     (br_disp),
        .field    (jmp_field),
        .seq_addr (seq_addr),
        .br_addr  (br_addr),
        .jmp_addr (jmp_addr)
    );

    pcu_select #(.ADDR_W(ADDR_W)) u_select (
        .cls        (instr_class),
        .eq         (ops_equal),
        .seq_addr   (seq_addr),
        .br_addr    (br_addr),
        .jmp_addr   (jmp_addr),
        .reg_addr   (reg_target),
        .next_addr  (next_addr),
        .bad_target (bad_target),
        .call       (link_we)
    );

    pcu_ctrl #(.ADDR_W(ADDR_W), .RESET_VEC(RESET_VEC)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .hold       (hold),
        .bad_target (bad_target),
        .next_addr  (next_addr),
        .pc_q       (pc),
        .fault      (misaligned)
    );

    assign link_addr = seq_addr;
endmodule

// File: rtl/pcu_checker.sv
module pcu_checker #(
    parameter int               ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] RESET_VEC = 32'h0040_0000
) (
    input logic              clk,
    input logic              rst,
    input logic              hold,
    input logic [2:0]        instr_class,
    input logic [25:0]       jmp_field,
    input logic [ADDR_W-1:0] reg_target,
    input logic [ADDR_W-1:0] pc,
    input logic [ADDR_W-1:0] link_addr,
    input logic              link_we,
    input logic              misaligned
);
    logic              armed;
    logic [ADDR_W-1:0] pc_inc;
    assign pc_inc = pc + ADDR_W'(4);

    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b1;
    end

    // R1
    reset_vector_chk: assert property (@(posedge clk) disable iff (armed !== 1'b1)
        rst |=> (pc == RESET_VEC && !misaligned));

    // R10
    hold_freeze_chk: assert property (@(posedge clk) disable iff (rst || armed !== 1'b1)
        hold |=> ($stable(pc) && $stable(misaligned)));

    // R2
    seq_step_chk: assert property (@(posedge clk) disable iff (rst || armed !== 1'b1)
        (!hold && instr_class == 3'd0) |=> (pc == $past(pc_inc)));

    // R6
    jump_region_chk: assert property (@(posedge clk) disable iff (rst || armed !== 1'b1)
        (!hold && instr_class == 3'd3) |=>
        (pc == {$past(pc_inc[ADDR_W-1 -: 4]), $past(jmp_field), 2'b00}));

    // R9
    bad_target_chk: assert property (@(posedge clk) disable iff (rst || armed !== 1'b1)
        (!hold && instr_class == 3'd5 && reg_target[1:0] != 2'b00) |=>
        (misaligned && $stable(pc)));

    // R7
    link_strobe_chk: assert property (@(posedge clk) disable iff (rst || armed !== 1'b1)
        link_we |-> (instr_class == 3'd4 && link_addr == pc_inc));

    // R8
    pc_aligned_chk: assert property (@(posedge clk) disable iff (rst || armed !== 1'b1)
        pc[1:0] == 2'b00);
endmodule

bind pc_next_unit pcu_checker #(.ADDR_W(ADDR_W), .RESET_VEC(RESET_VEC)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .hold        (hold),
    .instr_class (instr_class),
    .jmp_field   (jmp_field),
    .reg_target  (reg_target),
    .pc          (pc),
    .link_addr   (link_addr),
    .link_we     (link_we),
    .misaligned  (misaligned)
);

// File: tb/pc_next_unit_test.sv
module pc_next_unit_test;
    localparam logic [31:0] VEC = 32'h0040_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hold = 1'b0;
    logic [2:0]  instr_class = 3'd0;
    logic [15:0] br_disp = '0;
    logic [25:0] jmp_field = '0;
    logic [31:0] reg_target = '0;
    logic        ops_equal = 1'b0;
    logic [31:0] pc, link_addr;
    logic        link_we, misaligned;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] exp_pc;

    always #5 clk = ~clk;

    pc_next_unit uut (
        .clk(clk), .rst(rst), .hold(hold), .instr_class(instr_class),
        .br_disp(br_disp), .jmp_field(jmp_field), .reg_target(reg_target),
        .ops_equal(ops_equal), .pc(pc), .link_addr(link_addr),
        .link_we(link_we), .misaligned(misaligned)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [2:0] c, input logic [15:0] d, input logic [25:0] j,
                         input logic [31:0] r, input logic e);
        instr_class = c; br_disp = d; jmp_field = j; reg_target = r; ops_equal = e;
        @(negedge clk);
    endtask

    function automatic logic [31:0] jtarget(input logic [31:0] p, input logic [25:0] j);
        logic [31:0] n;
        n = p + 32'd4;
        return {n[31:28], j, 2'b00};
    endfunction

    task automatic t_reset();
        rst = 1'b1;
        apply(3'd3, 16'd0, 26'h155, 32'd0, 1'b0);
        apply(3'd0, 16'd0, 26'd0, 32'd0, 1'b0);
        check("R1 pc", pc, VEC);
        check("R1 misaligned", {31'd0, misaligned}, 32'd0);
        rst = 1'b0;
        exp_pc = VEC;
    endtask

    task automatic t_seq();
        for (int i = 0; i < 3; i++) begin
            apply(3'd0, 16'h7777, 26'h1234, 32'hDEAD_BEEF, 1'b1);
            exp_pc += 32'd4;
            check("R2 seq", pc, exp_pc);
        end
        apply(3'd6, 16'd5, 26'd0, 32'd0, 1'b1);
        exp_pc += 32'd4;
        check("R2 code6", pc, exp_pc);
        apply(3'd7, 16'd5, 26'd0, 32'd0, 1'b0);
        exp_pc += 32'd4;
        check("R2 code7", pc, exp_pc);
    endtask

    task automatic t_branch();
        apply(3'd1, 16'd25, 26'd0, 32'd0, 1'b1);
        exp_pc += 32'd104;
        check("R3 beq taken", pc, exp_pc);
        apply(3'd1, 16'd25, 26'd0, 32'd0, 1'b0);
        exp_pc += 32'd4;
        check("R3 beq not taken", pc, exp_pc);
        apply(3'd2, 16'd8, 26'd0, 32'd0, 1'b0);
        exp_pc += 32'd36;
        check("R4 bne taken", pc, exp_pc);
        apply(3'd2, 16'd8, 26'd0, 32'd0, 1'b1);
        exp_pc += 32'd4;
        check("R4 bne not taken", pc, exp_pc);
        apply(3'd1, 16'hFFFD, 26'd0, 32'd0, 1'b1);
        exp_pc = exp_pc + 32'd4 - 32'd12;
        check("R5 backward", pc, exp_pc);
    endtask

    task automatic t_jumps();
        apply(3'd5, 16'd0, 26'd0, 32'h0FFF_FFFC, 1'b0);
        exp_pc = 32'h0FFF_FFFC;
        check("R8 jr", pc, exp_pc);
        apply(3'd3, 16'd0, 26'h10, 32'd0, 1'b0);
        exp_pc = jtarget(exp_pc, 26'h10);
        check("R6 jump across region", pc, exp_pc);
        apply(3'd3, 16'd0, 26'h3FF_FFFF, 32'd0, 1'b0);
        exp_pc = jtarget(exp_pc, 26'h3FF_FFFF);
        check("R6 jump max field", pc, exp_pc);
        instr_class = 3'd4; jmp_field = 26'h100;
        #1;
        check("R7 link_we", {31'd0, link_we}, 32'd1);
        check("R7 link_addr", link_addr, exp_pc + 32'd4);
        @(negedge clk);
        exp_pc = jtarget(exp_pc, 26'h100);
        check("R7 jal target", pc, exp_pc);
        instr_class = 3'd3;
        #1;
        check("R7 no link on jump", {31'd0, link_we}, 32'd0);
        @(negedge clk);
        exp_pc = jtarget(exp_pc, 26'h100);
    endtask

    task automatic t_misalign();
        apply(3'd5, 16'd0, 26'd0, 32'h0040_1000, 1'b0);
        exp_pc = 32'h0040_1000;
        check("R8 jr aligned", pc, exp_pc);
        apply(3'd5, 16'd0, 26'd0, 32'h0040_2002, 1'b0);
        check("R9 pc kept", pc, exp_pc);
        check("R9 flag set", {31'd0, misaligned}, 32'd1);
        apply(3'd5, 16'd0, 26'd0, 32'h0040_3001, 1'b0);
        check("R9 pc kept again", pc, exp_pc);
        check("R9 flag stays", {31'd0, misaligned}, 32'd1);
        apply(3'd0, 16'd0, 26'd0, 32'd0, 1'b0);
        exp_pc += 32'd4;
        check("R9 flag clears", {31'd0, misaligned}, 32'd0);
        check("R9 pc resumes", pc, exp_pc);
    endtask

    task automatic t_hold();
        hold = 1'b1;
        apply(3'd3, 16'd0, 26'h5, 32'd0, 1'b0);
        check("R10 jump held", pc, exp_pc);
        hold = 1'b0;
        apply(3'd5, 16'd0, 26'd0, 32'h0000_0003, 1'b0);
        check("R9 flag before hold", {31'd0, misaligned}, 32'd1);
        hold = 1'b1;
        apply(3'd0, 16'd0, 26'd0, 32'd0, 1'b0);
        check("R10 flag held", {31'd0, misaligned}, 32'd1);
        check("R10 pc held", pc, exp_pc);
        hold = 1'b0;
        apply(3'd0, 16'd0, 26'd0, 32'd0, 1'b0);
        exp_pc += 32'd4;
        check("R10 released", pc, exp_pc);
        check("R10 flag released", {31'd0, misaligned}, 32'd0);
    endtask

    task automatic t_midreset();
        rst = 1'b1;
        apply(3'd5, 16'd0, 26'd0, 32'h0000_0002, 1'b0);
        check("R1 mid-run reset", pc, VEC);
        check("R1 mid-run flag", {31'd0, misaligned}, 32'd0);
        rst = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_seq();
        t_branch();
        t_jumps();
        t_misalign();
        t_hold();
        t_midreset();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule